// File: doc/BRIEF.md
# Inter-Block Gap Throttle

The block sits on a streaming valid/data path that carries complex correlator results in fixed-length blocks. Each block is one channel's set of visibilities, `BLK_LEN` words long, one word per clock. The throttle forwards every block unchanged and at full clock rate. It then keeps the output idle for a set number of cycles before the next block may start. This brings the average output rate down to what a slower link further on can carry, while the burst rate inside a block stays at one word per cycle.

Incoming words go into a small elastic FIFO. A block is released only once the whole block is buffered, so the output never has a hole inside a block. The idle length comes from the `gap_len` input. It is captured when the last word of a block leaves, so a change to `gap_len` during a countdown only applies to the next gap. Upstream ready is dropped during a countdown and when the FIFO is full. A word that arrives with no room for it is dropped and raises a sticky overflow flag.

Legal gap values depend on the system. The gap must be at least the link transfer time of one packet in clock cycles minus the block length. It must be at most the clock cycles per interval divided by the blocks per interval, minus the block length. A typical setting is a block length of 10 and a gap of 279, which lies between a lower limit of 278 and an upper limit of 1270.

Top module: `blk_gap_throttle`

## Requirements
- R1: After a synchronous active-high reset, `out_valid` is 0, `in_ready` is 1 and `overflow` is 0. Any buffered words and any running gap are discarded.
- R2: Each block leaves as `BLK_LEN` words on `BLK_LEN` consecutive cycles. The words are in arrival order, and `out_re` and `out_im` equal the values given at the input.
- R3: The first word of a block appears on the output in the cycle right after the clock edge that stores that block's last word. After reset, the first block has no leading gap.
- R4: After the last word of a block, `out_valid` stays low for exactly D cycles, where D is the value of `gap_len` in the cycle of that last word. If the next block is already buffered, its first word follows in the cycle after those D cycles.
- R5: With `gap_len` = 0, a block that is already buffered follows the previous block with no idle cycle.
- R6: A change to `gap_len` while a gap is counting down does not change that gap. The new value sets the length of the next gap.
- R7: `in_ready` is 0 in every cycle of a gap countdown, and in every cycle in which the FIFO holds `DEPTH` words. Otherwise it is 1.
- R8: A word presented with `in_valid` = 1 while the FIFO is full and no word leaves in that cycle is dropped. It never appears on the output. `overflow` then goes to 1 and stays 1 until reset.
- R9: `out_sync` leaves together with the word it entered with, so a marked word stays marked. `out_sync` is 0 whenever `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word present |
| in_re | input | DW | Real part of input visibility |
| in_im | input | DW | Imaginary part of input visibility |
| in_sync | input | 1 | Interval boundary marker for this word |
| in_ready | output | 1 | Upstream may send; low during a gap or when the FIFO is full |
| gap_len | input | GW | Idle cycles to insert after each block |
| out_valid | output | 1 | Output word present |
| out_re | output | DW | Real part of output visibility |
| out_im | output | DW | Imaginary part of output visibility |
| out_sync | output | 1 | Interval boundary marker travelling with the word |
| overflow | output | 1 | Sticky flag: a word was dropped because the FIFO was full |

## Verification
The bench builds the throttle with `BLK_LEN` = 4 and `DEPTH` = 8. With these values, exactly two blocks fill the FIFO, so a ninth word sent during a gap overflows it within a few cycles. With 8-bit data and gap fields, every word in a run gets a distinct value, and gaps from 0 to 40 can each be measured exactly. The small block length also allows two or three consecutive gaps in one run. This makes it possible to see a `gap_len` change taking effect only at the next gap.

// File: rtl/blk_gap_throttle.sv
module blk_gap_throttle #(
  parameter int DW      = 16,
  parameter int BLK_LEN = 10,
  parameter int DEPTH   = 16,
  parameter int GW      = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_re,
  input  logic [DW-1:0] in_im,
  input  logic          in_sync,
  output logic          in_ready,
  input  logic [GW-1:0] gap_len,
  output logic          out_valid,
  output logic [DW-1:0] out_re,
  output logic [DW-1:0] out_im,
  output logic          out_sync,
  output logic          overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int WW = (BLK_LEN > 1) ? $clog2(BLK_LEN) : 1;
  localparam int EW = 2 * DW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] BLK_CNT  = CW'(BLK_LEN);
  localparam logic [WW-1:0] LAST_W   = WW'(BLK_LEN - 1);
  localparam logic [AW-1:0] TOP_A    = AW'(DEPTH - 1);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic [WW-1:0] wc;
  logic [GW-1:0] gc;
  logic          sending;
  logic          ovf;

  wire full  = (cnt == FULL_CNT);
  wire quiet = (gc == '0);
  wire start = !sending && quiet && (cnt >= BLK_CNT);
  wire rd    = sending || start;
  wire wr    = in_valid && (!full || rd);
  wire last  = rd && (wc == LAST_W);

  wire [EW-1:0] head = mem[rp];

  always_ff @(posedge clk)
    if (wr) mem[wp] <= {in_sync, in_im, in_re};

  always_ff @(posedge clk) begin
    if (rst) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      wc      <= '0;
      gc      <= '0;
      sending <= 1'b0;
      ovf     <= 1'b0;
    end else begin
      if (wr) wp <= (wp == TOP_A) ? '0 : wp + AW'(1);
      if (rd) rp <= (rp == TOP_A) ? '0 : rp + AW'(1);
      cnt <= cnt + CW'(wr) - CW'(rd);
      ovf <= ovf || (in_valid && !wr);
      if (rd) begin
        if (last) begin
          wc      <= '0;
          sending <= 1'b0;
          gc      <= gap_len;
        end else begin
          wc      <= wc + WW'(1);
          sending <= 1'b1;
        end
      end else if (!quiet) begin
        gc <= gc - GW'(1);
      end
    end
  end

  assign in_ready  = !full && quiet;
  assign out_valid = rd;
  assign out_re    = rd ? head[DW-1:0]      : '0;
  assign out_im    = rd ? head[2*DW-1:DW]   : '0;
  assign out_sync  = rd && head[EW-1];
  assign overflow  = ovf;
endmodule

// File: rtl/blk_gap_throttle_chk.sv
module blk_gap_throttle_chk #(
  parameter int BLK_LEN = 10,
  parameter int GW      = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          in_ready,
  input logic [GW-1:0] gap_len,
  input logic          out_valid,
  input logic          out_sync,
  input logic          overflow
);
  localparam int WW = (BLK_LEN > 1) ? $clog2(BLK_LEN) : 1;
  localparam logic [WW-1:0] LAST_W = WW'(BLK_LEN - 1);

  logic [WW-1:0] seen;
  wire at_last = out_valid && (seen == LAST_W);

  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (out_valid) seen <= at_last ? '0 : seen + WW'(1);
  end

  a_r2_contiguous: assert property (@(posedge clk) disable iff (rst)
    out_valid && !at_last |=> out_valid);

  a_r4_gap_idle: assert property (@(posedge clk) disable iff (rst)
    at_last && (gap_len != '0) |=> !out_valid);

  a_r7_ready_low_in_gap: assert property (@(posedge clk) disable iff (rst)
    at_last && (gap_len != '0) |=> !in_ready);

  a_r8_sticky_overflow: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  a_r9_sync_with_valid: assert property (@(posedge clk) disable iff (rst)
    out_sync |-> out_valid);
endmodule

bind blk_gap_throttle blk_gap_throttle_chk #(.BLK_LEN(BLK_LEN), .GW(GW)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .gap_len(gap_len),
  .out_valid(out_valid), .out_sync(out_sync), .overflow(overflow)
);

// File: tb/blk_gap_throttle_bench.sv
module blk_gap_throttle_bench;
  localparam int PER = 10;
  localparam int DW = 8, BL = 4, DEP = 8, GW = 8;
  localparam int NROW = 5;
  localparam int GAP_TAB [NROW] = '{0, 1, 2, 7, 40};
  localparam int EXP_TAB [NROW] = '{0, 1, 2, 7, 40};
  localparam int SEED_TAB[NROW] = '{8'h10, 8'h31, 8'h52, 8'h73, 8'hC4};

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_sync = 1'b0;
  logic [DW-1:0] in_re = '0, in_im = '0;
  logic [GW-1:0] gap_len = '0;
  logic in_ready, out_valid, out_sync, overflow;
  logic [DW-1:0] out_re, out_im;

  int total = 0, bad = 0, cyc = 0, nout = 0;
  bit done = 1'b0;
  int o_cyc[256]; int o_re[256]; int o_im[256]; int o_sy[256];

  always #(PER/2) clk = ~clk;

  blk_gap_throttle #(.DW(DW), .BLK_LEN(BL), .DEPTH(DEP), .GW(GW)) u_blk_gap_throttle (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .in_sync(in_sync), .in_ready(in_ready), .gap_len(gap_len),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im),
    .out_sync(out_sync), .overflow(overflow));

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (out_valid && nout < 256) begin
      o_cyc[nout] = cyc; o_re[nout] = out_re; o_im[nout] = out_im; o_sy[nout] = out_sync;
      nout = nout + 1;
    end
  end

  function automatic int im_of(int v); return (v ^ 8'h5A) & 8'hFF; endfunction

  task automatic step(); @(negedge clk); #1; endtask

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic do_reset();
    in_valid = 1'b0; rst = 1'b1; step(); step(); rst = 1'b0;
  endtask

  task automatic put(int v, bit s);
    in_valid = 1'b1; in_re = DW'(v); in_im = DW'(im_of(v)); in_sync = s; step(); in_valid = 1'b0;
  endtask

  task automatic chk_word(int idx, int v, bit s, string req);
    chk(o_re[idx] == (v & 8'hFF), req, o_re[idx], v & 8'hFF);
    chk(o_im[idx] == im_of(v), req, o_im[idx], im_of(v));
    chk(o_sy[idx] == int'(s), {req, "/R9"}, o_sy[idx], int'(s));
  endtask

  initial begin
    #(PER * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int base;
    do_reset();
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    chk(overflow == 1'b0, "R1 overflow", overflow, 0);

    for (int r = 0; r < NROW; r++) begin
      do_reset();
      gap_len = GW'(GAP_TAB[r]);
      base = nout;
      for (int j = 0; j < 2 * BL; j++) put(SEED_TAB[r] + j, (j % BL) == 0);
      repeat (GAP_TAB[r] + 12) step();
      chk(nout - base == 2 * BL, "R2 count", nout - base, 2 * BL);
      for (int j = 0; j < 2 * BL; j++) chk_word(base + j, SEED_TAB[r] + j, (j % BL) == 0, "R2 data");
      for (int j = 1; j < BL; j++)
        chk(o_cyc[base + j] == o_cyc[base + j - 1] + 1, "R2 contiguous", o_cyc[base + j] - o_cyc[base + j - 1], 1);
      chk(o_cyc[base + BL] - o_cyc[base + BL - 1] - 1 == EXP_TAB[r],
          (GAP_TAB[r] == 0) ? "R5 gap" : "R4 gap", o_cyc[base + BL] - o_cyc[base + BL - 1] - 1, EXP_TAB[r]);
    end

    do_reset();
    gap_len = 8'd3;
    for (int j = 0; j < BL; j++) begin
      chk(out_valid == 1'b0, "R3 early", out_valid, 0);
      in_valid = 1'b1; in_re = DW'(8'h90 + j); in_im = DW'(im_of(8'h90 + j)); in_sync = 1'b0;
      step();
    end
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R3 start", out_valid, 1);
    chk(out_re == 8'h90, "R3 first word", out_re, 8'h90);

    do_reset();
    gap_len = 8'd10;
    base = nout;
    for (int j = 0; j < 2 * BL; j++) put(8'h20 + j, j == 0);
    gap_len = 8'd2;
    chk(in_ready == 1'b0, "R7 ready in gap", in_ready, 0);
    step(); step(); step();
    for (int j = 0; j < BL; j++) put(8'h60 + j, j == 0);
    repeat (40) step();
    chk(nout - base == 3 * BL, "R6 count", nout - base, 3 * BL);
    chk(o_cyc[base + BL] - o_cyc[base + BL - 1] - 1 == 10, "R6 gap kept",
        o_cyc[base + BL] - o_cyc[base + BL - 1] - 1, 10);
    chk(o_cyc[base + 2*BL] - o_cyc[base + 2*BL - 1] - 1 == 2, "R6 new gap",
        o_cyc[base + 2*BL] - o_cyc[base + 2*BL - 1] - 1, 2);
    chk_word(base + 2 * BL, 8'h60, 1'b1, "R6 data");

    do_reset();
    gap_len = 8'd30;
    base = nout;
    for (int j = 0; j < BL; j++) put(8'hA0 + j, 1'b0);
    repeat (BL) step();
    for (int j = 0; j < 2 * DEP; j++) if (j <= DEP) put(8'hB0 + j, 1'b0);
    chk(overflow == 1'b1, "R8 set", overflow, 1);
    chk(in_ready == 1'b0, "R7 ready full", in_ready, 0);
    begin
      bit seen = 1'b0;
      for (int k = 0; k < 60 && !seen; k++) begin
        if (out_valid) begin
          seen = 1'b1;
          chk(in_ready == 1'b0, "R7 full while sending", in_ready, 0);
          step();
          chk(in_ready == 1'b1, "R7 ready after read", in_ready, 1);
        end else step();
      end
      chk(seen, "R8 release", seen, 1);
    end
    repeat (60) step();
    chk(nout - base == 3 * BL, "R8 dropped word absent", nout - base, 3 * BL);
    for (int j = 0; j < 2 * BL; j++) chk_word(base + BL + j, 8'hB0 + j, 1'b0, "R8 data");
    chk(overflow == 1'b1, "R8 sticky", overflow, 1);
    do_reset();
    chk(overflow == 1'b0, "R1 overflow cleared", overflow, 0);
    chk(out_valid == 1'b0, "R1 buffer cleared", out_valid, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule